// File: doc/BRIEF.md
# Accumulator register and I/O instruction executor

This block carries out the two instruction groups of a 16-bit accumulator machine that need no memory operand. The first group, identified by opcode nibble 7 with the mode bit clear, works on the accumulator (AC) and its one-bit extension E. It clears and complements them, rotates the 17-bit pair, increments AC, tests AC or E for a conditional skip, and requests a halt. The second group, identified by upper nibble F, moves characters between AC and 8-bit input and output registers. It also tests their ready flags and switches interrupt enable on or off.

The sequencer presents an instruction word with the current AC, E and I/O flags, and pulses `exec_i` for one cycle. After the next rising clock edge the block presents the new AC and E. It can also present a one-cycle skip request, which the sequencer turns into an extra PC increment, a one-cycle halt request, or a one-cycle strobe toward the input or output register. Within each group, every operation is named by one bit of the low 12 bits. When several such bits are set, only the most significant one acts. Words from any other opcode pass AC and E through unchanged.

Top module: `regio_exec`

## Requirements
- R1: After reset, ac_o, e_o, skip_o, halt_o, ien_o, in_ack_o, out_we_o and out_data_o are all zero.
- R2: Results appear after the first rising edge that samples exec_i high. While exec_i is low, ac_o, e_o and ien_o hold their values.
- R3: 7800 clears AC, 7400 clears E, 7200 inverts every AC bit and 7100 inverts E. Each leaves the other register as given.
- R4: 7080 rotates {E,AC} right by one, so AC[15] takes E and E takes AC[0]. 7040 rotates it left by one, so AC[0] takes E and E takes AC[15].
- R5: 7020 adds one to AC modulo 2^16 and leaves E unchanged.
- R6: 7010 skips when AC[15] is 0 and AC is nonzero. 7008 skips when AC[15] is 1. 7004 skips when AC is zero. 7002 skips when E is 0.
- R7: 7001 raises halt_o for exactly one cycle.
- R8: A skip request is a single-cycle pulse on skip_o. Instructions that do not write AC or E pass ac_i and e_i to ac_o and e_o.
- R9: F800 replaces AC[7:0] with in_data_i, keeps AC[15:8], and pulses in_ack_o for one cycle so that the input flag is cleared.
- R10: F400 loads out_data_o with AC[7:0] and pulses out_we_o for one cycle so that the output flag is cleared. AC is unchanged, and out_data_o keeps its value until the next F400.
- R11: F200 skips when in_flag_i is 1, and F100 skips when out_flag_i is 1.
- R12: F080 sets ien_o and F040 clears it. No other instruction changes it.
- R13: When several operation bits are set, only the most significant one acts. For opcode 7 this covers bits 11..0, and for F it covers bits 11..6; bits 5..0 of an F word are ignored. Any other upper nibble is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe, one cycle per instruction |
| instr_i | input | 16 | Instruction word |
| ac_i | input | 16 | Current accumulator |
| e_i | input | 1 | Current extension bit |
| in_data_i | input | 8 | Input register contents |
| in_flag_i | input | 1 | Input register holds a character |
| out_flag_i | input | 1 | Output register is ready |
| ac_o | output | 16 | Next accumulator |
| e_o | output | 1 | Next extension bit |
| skip_o | output | 1 | Skip-next-instruction request |
| halt_o | output | 1 | Halt request |
| ien_o | output | 1 | Interrupt enable state |
| in_ack_o | output | 1 | Clear strobe for the input flag |
| out_data_o | output | 8 | Character for the output register |
| out_we_o | output | 1 | Output register write strobe, clears output flag |

## Verification
Every code is exercised against operands that separate it from its neighbours. The rotate operands carry a set bit at the end that crosses into E, so right and left, and 16-bit versus 17-bit width, give different answers. The increment uses all-ones to show the wrap and that E is kept. The skip tests pair each condition with zero, the sign bit and a small positive value, so that "positive" is told apart from "not negative". Words with several bits set, I/O words with only low bits set, and foreign opcodes show which bit wins and that nothing else acts.

// File: rtl/regio_pkg.sv
package regio_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned CHAR_W  = 8;
  localparam int unsigned OPC_W   = 4;
  localparam int unsigned FIELD_W = WORD_W - OPC_W;
  localparam int unsigned IO_LSB  = 6;  // lowest bit naming an I/O operation

  localparam logic [OPC_W-1:0] OPC_REG = 4'h7;
  localparam logic [OPC_W-1:0] OPC_IO  = 4'hF;

  typedef enum logic [4:0] {
    OP_NONE, OP_CLA, OP_CLE, OP_CMA, OP_CME, OP_CIR, OP_CIL, OP_INC,
    OP_SPA, OP_SNA, OP_SZA, OP_SZE, OP_HLT,
    OP_INP, OP_OUT, OP_SKI, OP_SKO, OP_ION, OP_IOF
  } rio_op_e;
endpackage

// File: rtl/regio_decode.sv
module regio_decode
  import regio_pkg::*;
(
  input  logic [WORD_W-1:0] instr_i,
  output rio_op_e           op_o
);
  logic [OPC_W-1:0]   opc;
  logic [FIELD_W-1:0] field;
  int                 top_idx;
  logic               hit;

  assign opc   = instr_i[WORD_W-1 -: OPC_W];
  assign field = instr_i[FIELD_W-1:0];

  // highest set bit wins
  always_comb begin
    hit     = 1'b0;
    top_idx = 0;
    for (int i = 0; i < int'(FIELD_W); i++) begin
      if (field[i]) begin
        hit     = 1'b1;
        top_idx = i;
      end
    end
  end

  always_comb begin
    op_o = OP_NONE;
    if (hit && opc == OPC_REG) begin
      case (top_idx)
        11: op_o = OP_CLA;
        10: op_o = OP_CLE;
        9:  op_o = OP_CMA;
        8:  op_o = OP_CME;
        7:  op_o = OP_CIR;
        6:  op_o = OP_CIL;
        5:  op_o = OP_INC;
        4:  op_o = OP_SPA;
        3:  op_o = OP_SNA;
        2:  op_o = OP_SZA;
        1:  op_o = OP_SZE;
        default: op_o = OP_HLT;
      endcase
    end else if (hit && opc == OPC_IO && top_idx >= int'(IO_LSB)) begin
      case (top_idx)
        11: op_o = OP_INP;
        10: op_o = OP_OUT;
        9:  op_o = OP_SKI;
        8:  op_o = OP_SKO;
        7:  op_o = OP_ION;
        default: op_o = OP_IOF;
      endcase
    end
  end
endmodule

// File: rtl/regio_acc_unit.sv
module regio_acc_unit
  import regio_pkg::*;
(
  input  rio_op_e           op_i,
  input  logic [WORD_W-1:0] ac_i,
  input  logic              e_i,
  input  logic [CHAR_W-1:0] in_data_i,
  input  logic              in_flag_i,
  input  logic              out_flag_i,
  output logic [WORD_W-1:0] ac_nx_o,
  output logic              e_nx_o,
  output logic              skip_nx_o,
  output logic              halt_nx_o
);
  logic ac_zero, ac_neg;
  assign ac_zero = (ac_i == '0);
  assign ac_neg  = ac_i[WORD_W-1];

  always_comb begin
    ac_nx_o   = ac_i;
    e_nx_o    = e_i;
    skip_nx_o = 1'b0;
    halt_nx_o = 1'b0;
    unique case (op_i)
      OP_CLA: ac_nx_o = '0;
      OP_CLE: e_nx_o  = 1'b0;
      OP_CMA: ac_nx_o = ~ac_i;
      OP_CME: e_nx_o  = ~e_i;
      OP_CIR: {ac_nx_o, e_nx_o} = {e_i, ac_i};
      OP_CIL: {e_nx_o, ac_nx_o} = {ac_i, e_i};
      OP_INC: ac_nx_o = ac_i + 1'b1;
      OP_SPA: skip_nx_o = !ac_neg && !ac_zero;
      OP_SNA: skip_nx_o = ac_neg;
      OP_SZA: skip_nx_o = ac_zero;
      OP_SZE: skip_nx_o = !e_i;
      OP_HLT: halt_nx_o = 1'b1;
      OP_INP: ac_nx_o = {ac_i[WORD_W-1:CHAR_W], in_data_i};
      OP_SKI: skip_nx_o = in_flag_i;
      OP_SKO: skip_nx_o = out_flag_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/regio_io_unit.sv
module regio_io_unit
  import regio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  rio_op_e           op_i,
  input  logic [CHAR_W-1:0] ac_lo_i,
  output logic              ien_o,
  output logic              in_ack_o,
  output logic [CHAR_W-1:0] out_data_o,
  output logic              out_we_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_o      <= 1'b0;
      in_ack_o   <= 1'b0;
      out_we_o   <= 1'b0;
      out_data_o <= '0;
    end else begin
      in_ack_o <= exec_i && op_i == OP_INP;
      out_we_o <= exec_i && op_i == OP_OUT;
      if (exec_i && op_i == OP_OUT) out_data_o <= ac_lo_i;
      if (exec_i && op_i == OP_ION) ien_o <= 1'b1;
      else if (exec_i && op_i == OP_IOF) ien_o <= 1'b0;
    end
  end

  a_r12_ien_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(ien_o));
  a_r10_out_we_strobed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_o |-> $past(exec_i));
  a_r10_out_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(out_data_o));
endmodule

// File: rtl/regio_exec.sv
module regio_exec
  import regio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] ac_i,
  input  logic              e_i,
  input  logic [CHAR_W-1:0] in_data_i,
  input  logic              in_flag_i,
  input  logic              out_flag_i,
  output logic [WORD_W-1:0] ac_o,
  output logic              e_o,
  output logic              skip_o,
  output logic              halt_o,
  output logic              ien_o,
  output logic              in_ack_o,
  output logic [CHAR_W-1:0] out_data_o,
  output logic              out_we_o
);
  rio_op_e           op;
  logic [WORD_W-1:0] ac_nx;
  logic              e_nx, skip_nx, halt_nx;

  regio_decode u_dec (.instr_i(instr_i), .op_o(op));

  regio_acc_unit u_acc (
    .op_i(op), .ac_i(ac_i), .e_i(e_i), .in_data_i(in_data_i),
    .in_flag_i(in_flag_i), .out_flag_i(out_flag_i),
    .ac_nx_o(ac_nx), .e_nx_o(e_nx), .skip_nx_o(skip_nx), .halt_nx_o(halt_nx)
  );

  regio_io_unit u_io (
    .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .op_i(op),
    .ac_lo_i(ac_i[CHAR_W-1:0]), .ien_o(ien_o), .in_ack_o(in_ack_o),
    .out_data_o(out_data_o), .out_we_o(out_we_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_o   <= '0;
      e_o    <= 1'b0;
      skip_o <= 1'b0;
      halt_o <= 1'b0;
    end else begin
      skip_o <= exec_i && skip_nx;
      halt_o <= exec_i && halt_nx;
      if (exec_i) begin
        ac_o <= ac_nx;
        e_o  <= e_nx;
      end
    end
  end

  a_r2_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(ac_o) && $stable(e_o)));
  a_r8_skip_strobed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> $past(exec_i));
  a_r7_halt_strobed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> $past(exec_i));
  a_r13_single_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({skip_o, halt_o, in_ack_o, out_we_o}));
endmodule

// File: tb/regio_exec_test.sv
`timescale 1ns/1ps
module regio_exec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [15:0] instr = '0, ac_in = '0;
  logic        e_in = 1'b0, fin = 1'b0, fout = 1'b0;
  logic [7:0]  din = '0;
  logic [15:0] ac_out;
  logic        e_out, skip, halt, ien, in_ack, out_we;
  logic [7:0]  out_data;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  regio_exec uut (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .instr_i(instr), .ac_i(ac_in),
    .e_i(e_in), .in_data_i(din), .in_flag_i(fin), .out_flag_i(fout),
    .ac_o(ac_out), .e_o(e_out), .skip_o(skip), .halt_o(halt), .ien_o(ien),
    .in_ack_o(in_ack), .out_data_o(out_data), .out_we_o(out_we)
  );

  typedef struct packed {
    logic [15:0] instr; logic [15:0] ac; logic e; logic [7:0] din;
    logic fin; logic fout; logic [15:0] xac; logic xe; logic xskip;
    logic xhalt; logic [7:0] req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{16'h7800,16'h1234,1'b1,8'h00,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,8'd3},  // R3
    '{16'h7400,16'h1234,1'b1,8'h00,1'b0,1'b0,16'h1234,1'b0,1'b0,1'b0,8'd3},  // R3
    '{16'h7200,16'h00FF,1'b0,8'h00,1'b0,1'b0,16'hFF00,1'b0,1'b0,1'b0,8'd3},  // R3
    '{16'h7100,16'h5555,1'b0,8'h00,1'b0,1'b0,16'h5555,1'b1,1'b0,1'b0,8'd3},  // R3
    '{16'h7080,16'h0001,1'b1,8'h00,1'b0,1'b0,16'h8000,1'b1,1'b0,1'b0,8'd4},  // R4
    '{16'h7080,16'h8002,1'b0,8'h00,1'b0,1'b0,16'h4001,1'b0,1'b0,1'b0,8'd4},  // R4
    '{16'h7040,16'h8000,1'b0,8'h00,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,8'd4},  // R4
    '{16'h7040,16'h4001,1'b1,8'h00,1'b0,1'b0,16'h8003,1'b0,1'b0,1'b0,8'd4},  // R4
    '{16'h7020,16'hFFFF,1'b0,8'h00,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,8'd5},  // R5
    '{16'h7020,16'h00FF,1'b1,8'h00,1'b0,1'b0,16'h0100,1'b1,1'b0,1'b0,8'd5},  // R5
    '{16'h7010,16'h0001,1'b0,8'h00,1'b0,1'b0,16'h0001,1'b0,1'b1,1'b0,8'd6},  // R6
    '{16'h7010,16'h0000,1'b0,8'h00,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,8'd6},  // R6
    '{16'h7010,16'h8000,1'b0,8'h00,1'b0,1'b0,16'h8000,1'b0,1'b0,1'b0,8'd6},  // R6
    '{16'h7008,16'h8000,1'b1,8'h00,1'b0,1'b0,16'h8000,1'b1,1'b1,1'b0,8'd6},  // R6
    '{16'h7008,16'h7FFF,1'b0,8'h00,1'b0,1'b0,16'h7FFF,1'b0,1'b0,1'b0,8'd6},  // R6
    '{16'h7004,16'h0000,1'b1,8'h00,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b0,8'd6},  // R6
    '{16'h7004,16'h0001,1'b0,8'h00,1'b0,1'b0,16'h0001,1'b0,1'b0,1'b0,8'd6},  // R6
    '{16'h7002,16'h1111,1'b0,8'h00,1'b0,1'b0,16'h1111,1'b0,1'b1,1'b0,8'd6},  // R6
    '{16'h7002,16'h1111,1'b1,8'h00,1'b0,1'b0,16'h1111,1'b1,1'b0,1'b0,8'd6},  // R6
    '{16'h7001,16'h2222,1'b0,8'h00,1'b0,1'b0,16'h2222,1'b0,1'b0,1'b1,8'd7},  // R7
    '{16'hF200,16'h3333,1'b0,8'h00,1'b1,1'b0,16'h3333,1'b0,1'b1,1'b0,8'd11}, // R11
    '{16'hF200,16'h3333,1'b0,8'h00,1'b0,1'b1,16'h3333,1'b0,1'b0,1'b0,8'd11}, // R11
    '{16'hF100,16'h4444,1'b1,8'h00,1'b0,1'b1,16'h4444,1'b1,1'b1,1'b0,8'd11}, // R11
    '{16'hF100,16'h4444,1'b1,8'h00,1'b1,1'b0,16'h4444,1'b1,1'b0,1'b0,8'd11}, // R11
    '{16'hF800,16'hABCD,1'b0,8'h5A,1'b1,1'b0,16'hAB5A,1'b0,1'b0,1'b0,8'd9},  // R9
    '{16'hF400,16'h1234,1'b1,8'h00,1'b0,1'b0,16'h1234,1'b1,1'b0,1'b0,8'd10}, // R10
    '{16'h7C00,16'h1234,1'b1,8'h00,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,8'd13}, // R13
    '{16'h7011,16'h0001,1'b0,8'h00,1'b0,1'b0,16'h0001,1'b0,1'b1,1'b0,8'd13}, // R13
    '{16'h3100,16'h1234,1'b1,8'h00,1'b0,1'b0,16'h1234,1'b1,1'b0,1'b0,8'd13}, // R13
    '{16'h7000,16'hABCD,1'b0,8'h00,1'b0,1'b0,16'hABCD,1'b0,1'b0,1'b0,8'd13}, // R13
    '{16'hFC00,16'h1200,1'b0,8'h77,1'b0,1'b0,16'h1277,1'b0,1'b0,1'b0,8'd13}, // R13
    '{16'h8001,16'h5678,1'b1,8'h00,1'b0,1'b0,16'h5678,1'b1,1'b0,1'b0,8'd13}, // R13
    '{16'hF03F,16'h9999,1'b0,8'h00,1'b1,1'b1,16'h9999,1'b0,1'b0,1'b0,8'd13}, // R13
    '{16'h7060,16'h8000,1'b0,8'h00,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,8'd13}  // R13
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one strobe at a falling edge, return at the next falling edge
  task automatic run(logic [15:0] i, logic [15:0] a, logic e, logic [7:0] d,
                     logic fi, logic fo);
    @(negedge clk);
    instr = i; ac_in = a; e_in = e; din = d; fin = fi; fout = fo; exec = 1'b1;
    @(negedge clk);
    exec = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ac", ac_out, 16'h0);
    check("R1 flags", {10'b0, e_out, skip, halt, ien, in_ack, out_we}, 16'h0);
    check("R1 out_data", {8'h0, out_data}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].instr, VECS[i].ac, VECS[i].e, VECS[i].din, VECS[i].fin, VECS[i].fout);
      check($sformatf("R%0d vec %0d ac", VECS[i].req, i), ac_out, VECS[i].xac);
      check($sformatf("R%0d vec %0d e", VECS[i].req, i), {15'b0, e_out}, {15'b0, VECS[i].xe});
      check($sformatf("R%0d vec %0d skip", VECS[i].req, i), {15'b0, skip}, {15'b0, VECS[i].xskip});
      check($sformatf("R%0d vec %0d halt", VECS[i].req, i), {15'b0, halt}, {15'b0, VECS[i].xhalt});
    end

    // R2: outputs hold while no strobe, inputs changing
    run(16'h7200, 16'h0F0F, 1'b1, 8'h00, 1'b0, 1'b0);
    ac_in = 16'h1111; e_in = 1'b0; instr = 16'h7800;
    repeat (3) @(negedge clk);
    check("R2 ac hold", ac_out, 16'hF0F0);
    check("R2 e hold", {15'b0, e_out}, 16'h1);

    // R8: skip pulse ends after one cycle
    run(16'h7004, 16'h0000, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R8 skip high", {15'b0, skip}, 16'h1);
    @(negedge clk);
    check("R8 skip low", {15'b0, skip}, 16'h0);

    // R7: halt pulse ends after one cycle
    run(16'h7001, 16'h0000, 1'b0, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    check("R7 halt low", {15'b0, halt}, 16'h0);

    // R9: input acknowledge strobe
    run(16'hF800, 16'h0000, 1'b0, 8'hC3, 1'b1, 1'b0);
    check("R9 in_ack high", {15'b0, in_ack}, 16'h1);
    @(negedge clk);
    check("R9 in_ack low", {15'b0, in_ack}, 16'h0);

    // R10: output strobe and held data
    run(16'hF400, 16'hBE34, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R10 out_we high", {15'b0, out_we}, 16'h1);
    check("R10 out_data", {8'h0, out_data}, 16'h0034);
    check("R10 in_ack quiet", {15'b0, in_ack}, 16'h0);
    run(16'h7200, 16'h00AA, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R10 out_we low", {15'b0, out_we}, 16'h0);
    check("R10 out_data held", {8'h0, out_data}, 16'h0034);

    // R12: interrupt enable
    run(16'hF080, 16'h0000, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R12 ion", {15'b0, ien}, 16'h1);
    run(16'h7800, 16'h0000, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R12 other op keeps", {15'b0, ien}, 16'h1);
    run(16'hF03F, 16'h0000, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R13 low io bits ignored", {15'b0, ien}, 16'h1);
    run(16'hF040, 16'h0000, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R12 iof", {15'b0, ien}, 16'h0);
    run(16'hF0C0, 16'h0000, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R13 ion over iof", {15'b0, ien}, 16'h1);

    summary();
    $finish;
  end
endmodule